// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches at fetch time. Two component predictors work side by side. The local side is two-level: a PC-indexed table holds a short outcome history for each branch, and that history selects a 3-bit saturating counter. The global side uses a global history register to select a 2-bit saturating counter. A chooser table, also indexed by the global history, decides which component's guess is given out for each branch. The fetch stage presents a PC and gets back a direction, a flag that says which component supplied it, and the global history value in use. The fetch stage keeps that history value with the branch as a snapshot.

When a branch resolves, the back end returns its PC, its real outcome, its snapshot and a mispredict flag. The block then trains both component counters and the per-branch history. It trains the chooser only when the two components disagreed. The global history is shifted with each guess as the guess is made. After a mispredict it is rebuilt from the snapshot plus the real outcome.

After reset a small controller with two states, ST_CLEAR and ST_READY, sweeps every table entry to its initial value. Reset always enters ST_CLEAR. The transition from ST_CLEAR to ST_READY is taken once the sweep index reaches its last value. ST_READY then holds until the next reset. Both ports are ignored while the controller is in ST_CLEAR.

Top module: `tournament_predictor`

## Requirements
- R1: After reset the `ready` output is low for exactly 2^GH_W clock edges (4096 by default) and then stays high until the next reset. Once ready, an untrained predictor gives not-taken, reports the local component (`pred_use_global` = 0) and shows a global history of zero.
- R2: The local guess is the most significant bit of a 3-bit counter. That counter is selected by a 10-bit history, which is read from a 1024-entry table indexed by PC bits [11:2].
- R3: The global guess is the most significant bit of a 2-bit counter in a 4096-entry table indexed by the 12-bit global history.
- R4: A 2-bit chooser entry, indexed by the global history, picks the component. MSB 1 means global. `pred_use_global` reports the choice, and `pred_taken` equals the chosen component's guess.
- R5: An accepted prediction (`pred_valid` while ready) shifts the guessed direction into bit 0 of the global history on the next edge. `pred_ghist` shows the value used for the current guess.
- R6: An update with `upd_mispredict` set makes the global history {upd_ghist[10:0], upd_taken}. This takes priority over a prediction in the same cycle.
- R7: Every accepted update moves both component counters one step toward the outcome and saturates them at their limits. The local counter used is the one selected by the branch's history before this update. The global counter used is the one at `upd_ghist`.
- R8: Every accepted update shifts the outcome into bit 0 of the PC's local history entry.
- R9: The chooser entry at `upd_ghist` moves one saturating step toward whichever component was right, and only when the two components disagreed.
- R10: While not ready, predictions and updates change nothing. An update without a mispredict, or a cycle with no accepted prediction, leaves the global history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | Table sweep finished; ports are honoured |
| pred_valid | input | 1 | A branch is being predicted this cycle |
| pred_pc | input | 32 | PC of the branch being predicted |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_use_global | output | 1 | 1 when the global component was chosen |
| pred_ghist | output | 12 | Global history used for this guess (snapshot) |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_mispredict | input | 1 | The earlier guess for this branch was wrong |
| upd_ghist | input | 12 | Snapshot of the global history taken at prediction |

## Verification
A branch that is always taken, repeated past the history length, shows the local history filling and its counter saturating. It tells the local path apart from the global one. A snapshot forced in by a mispredict, followed by taken outcomes, trains the global counter at one fixed index only. A not-taken outcome at a point where the two components disagree shows the chooser flipping to the global side after a single step, while an agreeing outcome does not move it. Back-to-back guesses, a prediction in the same cycle as a repair, and stimulus during the sweep separate speculative shifting, repair priority and the ignore rule. A long mixed run then sends loop-shaped outcome patterns of different periods from eight PCs through a reference model.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        ST_CLEAR,
        ST_READY
    } tbp_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
    import tbp_pkg::*;
#(
    parameter int CLR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_en,
    output logic [CLR_W-1:0] clr_idx,
    output logic             ready
);

    tbp_state_e       state_q, state_d;
    logic [CLR_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = (&idx_q) ? ST_READY : ST_CLEAR;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clr_en = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_READY: ready  = 1'b1;
            default:  clr_en = 1'b1;
        endcase
    end

    assign clr_idx = idx_q;

endmodule

// File: rtl/tbp_table.sv
module tbp_table #(
    parameter int                IDX_W  = 10,
    parameter int                DATA_W = 2,
    parameter bit                SHIFT  = 1'b0,
    parameter logic [DATA_W-1:0] INIT   = '0
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  tr_idx,
    output logic [DATA_W-1:0] tr_data,
    input  logic              tr_en,
    input  logic              tr_dir
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] nxt;

    assign rd_data = mem[rd_idx];
    assign tr_data = mem[tr_idx];

    generate
        if (SHIFT) begin : g_shift
            assign nxt = {tr_data[DATA_W-2:0], tr_dir};
        end else begin : g_sat
            always_comb begin
                nxt = tr_data;
                if (tr_dir && (tr_data != {DATA_W{1'b1}})) begin
                    nxt = tr_data + 1'b1;
                end else if (!tr_dir && (tr_data != '0)) begin
                    nxt = tr_data - 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= INIT;
        end else if (tr_en) begin
            mem[tr_idx] <= nxt;
        end
    end

endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spec_en,
    input  logic            spec_dir,
    input  logic            fix_en,
    input  logic [GH_W-1:0] fix_snap,
    input  logic            fix_dir,
    output logic [GH_W-1:0] ghist
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (fix_en) begin
            ghist <= {fix_snap[GH_W-2:0], fix_dir};
        end else if (spec_en) begin
            ghist <= {ghist[GH_W-2:0], spec_dir};
        end
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tbp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int LHT_IDX_W = 10,
    parameter int LH_W      = 10,
    parameter int LC_W      = 3,
    parameter int GH_W      = 12,
    parameter int GC_W      = 2,
    parameter int CH_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready,
    input  logic            pred_valid,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_use_global,
    output logic [GH_W-1:0] pred_ghist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_mispredict,
    input  logic [GH_W-1:0] upd_ghist
);

    localparam int CLR_W = imax(imax(LHT_IDX_W, LH_W), GH_W);
    localparam logic [LC_W-1:0] LC_INIT = {1'b0, {(LC_W-1){1'b1}}};
    localparam logic [GC_W-1:0] GC_INIT = {1'b0, {(GC_W-1){1'b1}}};
    localparam logic [CH_W-1:0] CH_INIT = {1'b0, {(CH_W-1){1'b1}}};

    logic             clr_en;
    logic [CLR_W-1:0] clr_idx;
    logic             upd_go;

    logic [LHT_IDX_W-1:0] p_li, u_li;
    logic [LH_W-1:0]      lh_p, lh_u;
    logic [LC_W-1:0]      lc_p, lc_u;
    logic [GC_W-1:0]      gc_p, gc_u;
    logic [CH_W-1:0]      ch_p, ch_u;
    logic                 loc_u, glb_u;

    tbp_ctrl #(.CLR_W(CLR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .ready   (ready)
    );

    assign p_li   = pred_pc[LHT_IDX_W+1:2];
    assign u_li   = upd_pc[LHT_IDX_W+1:2];
    assign upd_go = ready & upd_valid;

    // per-branch history table
    tbp_table #(.IDX_W(LHT_IDX_W), .DATA_W(LH_W), .SHIFT(1'b1), .INIT('0)) u_lht (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[LHT_IDX_W-1:0]),
        .rd_idx  (p_li),
        .rd_data (lh_p),
        .tr_idx  (u_li),
        .tr_data (lh_u),
        .tr_en   (upd_go),
        .tr_dir  (upd_taken)
    );

    // local counters, selected by per-branch history
    tbp_table #(.IDX_W(LH_W), .DATA_W(LC_W), .SHIFT(1'b0), .INIT(LC_INIT)) u_lct (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[LH_W-1:0]),
        .rd_idx  (lh_p),
        .rd_data (lc_p),
        .tr_idx  (lh_u),
        .tr_data (lc_u),
        .tr_en   (upd_go),
        .tr_dir  (upd_taken)
    );

    // global counters, selected by global history
    tbp_table #(.IDX_W(GH_W), .DATA_W(GC_W), .SHIFT(1'b0), .INIT(GC_INIT)) u_gct (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[GH_W-1:0]),
        .rd_idx  (pred_ghist),
        .rd_data (gc_p),
        .tr_idx  (upd_ghist),
        .tr_data (gc_u),
        .tr_en   (upd_go),
        .tr_dir  (upd_taken)
    );

    assign loc_u = lc_u[LC_W-1];
    assign glb_u = gc_u[GC_W-1];

    // chooser, trained only on disagreement
    tbp_table #(.IDX_W(GH_W), .DATA_W(CH_W), .SHIFT(1'b0), .INIT(CH_INIT)) u_ch (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[GH_W-1:0]),
        .rd_idx  (pred_ghist),
        .rd_data (ch_p),
        .tr_idx  (upd_ghist),
        .tr_data (ch_u),
        .tr_en   (upd_go & (loc_u != glb_u)),
        .tr_dir  (glb_u == upd_taken)
    );

    tbp_ghr #(.GH_W(GH_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (ready & pred_valid),
        .spec_dir (pred_taken),
        .fix_en   (upd_go & upd_mispredict),
        .fix_snap (upd_ghist),
        .fix_dir  (upd_taken),
        .ghist    (pred_ghist)
    );

    assign pred_use_global = ch_p[CH_W-1];
    assign pred_taken      = pred_use_global ? gc_p[GC_W-1] : lc_p[LC_W-1];

    logic unused_bits;
    assign unused_bits = ^{pred_pc[PC_W-1:LHT_IDX_W+2], pred_pc[1:0],
                           upd_pc[PC_W-1:LHT_IDX_W+2], upd_pc[1:0],
                           lc_p[LC_W-2:0], lc_u[LC_W-2:0], gc_p[GC_W-2:0],
                           gc_u[GC_W-2:0], ch_p[CH_W-2:0], ch_u};

endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
    parameter int GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready,
    input logic            pred_valid,
    input logic            pred_taken,
    input logic [GH_W-1:0] pred_ghist,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic            upd_mispredict,
    input logic [GH_W-1:0] upd_ghist
);

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1
    clear_ghist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (pred_ghist == '0));

    // R5
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pred_valid && !(upd_valid && upd_mispredict))
        |=> (pred_ghist == {$past(pred_ghist[GH_W-2:0]), $past(pred_taken)}));

    // R6
    repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upd_valid && upd_mispredict)
        |=> (pred_ghist == {$past(upd_ghist[GH_W-2:0]), $past(upd_taken)}));

    // R10
    ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ready && pred_valid) && !(ready && upd_valid && upd_mispredict))
        |=> $stable(pred_ghist));

endmodule

bind tournament_predictor tbp_chk #(.GH_W(GH_W)) u_tbp_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready          (ready),
    .pred_valid     (pred_valid),
    .pred_taken     (pred_taken),
    .pred_ghist     (pred_ghist),
    .upd_valid      (upd_valid),
    .upd_taken      (upd_taken),
    .upd_mispredict (upd_mispredict),
    .upd_ghist      (upd_ghist)
);

// File: tb/tb_tournament_predictor.sv
module tb_tournament_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        pred_use_global;
    logic [11:0] pred_ghist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        upd_mispredict = 1'b0;
    logic [11:0] upd_ghist = '0;

    always #2 clk = ~clk;

    tournament_predictor dut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_global(pred_use_global), .pred_ghist(pred_ghist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_mispredict(upd_mispredict), .upd_ghist(upd_ghist)
    );

    typedef struct {
        bit        taken;
        bit        src;
        bit [11:0] gh;
        string     tag;
    } exp_t;

    exp_t  q[$];
    event  ev;
    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";

    // reference model
    bit [9:0]  m_lht [1024];
    bit [2:0]  m_lct [1024];
    bit [1:0]  m_gct [4096];
    bit [1:0]  m_ch  [4096];
    bit [11:0] m_ghr;

    function automatic bit [2:0] sat3(bit [2:0] v, bit d);
        if (d && v != 3'd7) return v + 3'd1;
        if (!d && v != 3'd0) return v - 3'd1;
        return v;
    endfunction

    function automatic bit [1:0] sat2(bit [1:0] v, bit d);
        if (d && v != 2'd3) return v + 2'd1;
        if (!d && v != 2'd0) return v - 2'd1;
        return v;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lct[i] = 3'd3; end
        for (int i = 0; i < 4096; i++) begin m_gct[i] = 2'd1; m_ch[i] = 2'd1; end
        m_ghr = '0;
    endfunction

    function automatic void model_pred(bit [31:0] pc, output bit t, output bit s);
        bit lp, gp;
        lp = m_lct[m_lht[pc[11:2]]][2];
        gp = m_gct[m_ghr][1];
        s  = m_ch[m_ghr][1];
        t  = s ? gp : lp;
    endfunction

    function automatic void model_upd(bit [31:0] pc, bit t, bit [11:0] snap, bit mis);
        bit [9:0] h;
        bit lp, gp;
        h  = m_lht[pc[11:2]];
        lp = m_lct[h][2];
        gp = m_gct[snap][1];
        if (lp != gp) m_ch[snap] = sat2(m_ch[snap], gp == t);
        m_lct[h]    = sat3(m_lct[h], t);
        m_gct[snap] = sat2(m_gct[snap], t);
        m_lht[pc[11:2]] = {h[8:0], t};
        if (mis) m_ghr = {snap[10:0], t};
    endfunction

    task automatic check(string tag, bit ok, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // monitor: compares design outputs with queued expectations
    initial begin
        forever begin
            exp_t e;
            @(ev);
            #1;
            e = q.pop_front();
            check(e.tag,
                  (pred_taken === e.taken) && (pred_use_global === e.src) && (pred_ghist === e.gh),
                  $sformatf("taken=%0b glob=%0b gh=%03h", pred_taken, pred_use_global, pred_ghist),
                  $sformatf("taken=%0b glob=%0b gh=%03h", e.taken, e.src, e.gh));
        end
    end

    // driver tasks
    task automatic do_pred(input bit [31:0] pc, output bit [11:0] snap, output bit pt);
        exp_t e;
        @(negedge clk);
        pred_valid = 1'b1;
        pred_pc    = pc;
        model_pred(pc, e.taken, e.src);
        e.gh  = m_ghr;
        e.tag = cur_tag;
        q.push_back(e);
        -> ev;
        snap  = m_ghr;
        pt    = e.taken;
        m_ghr = {m_ghr[10:0], e.taken};
        @(posedge clk);
        #1 pred_valid = 1'b0;
    endtask

    task automatic do_upd(input bit [31:0] pc, input bit t, input bit [11:0] snap, input bit mis);
        @(negedge clk);
        upd_valid      = 1'b1;
        upd_pc         = pc;
        upd_taken      = t;
        upd_ghist      = snap;
        upd_mispredict = mis;
        model_upd(pc, t, snap, mis);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        upd_mispredict = 1'b0;
    endtask

    task automatic do_both(input bit [31:0] ppc, input bit [31:0] upc, input bit t, input bit [11:0] snap);
        exp_t e;
        @(negedge clk);
        pred_valid = 1'b1; pred_pc = ppc;
        upd_valid = 1'b1; upd_pc = upc; upd_taken = t; upd_ghist = snap; upd_mispredict = 1'b1;
        model_pred(ppc, e.taken, e.src);
        e.gh = m_ghr; e.tag = cur_tag;
        q.push_back(e);
        -> ev;
        model_upd(upc, t, snap, 1'b1);
        @(posedge clk);
        #1 pred_valid = 1'b0;
        upd_valid = 1'b0; upd_mispredict = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        bit [11:0] snap;
        bit        pt;
        int        n;
        int        cnt [8];
        bit [31:0] lfsr;

        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", (ready === 1'b0) && (pred_ghist === 12'h000),
              $sformatf("ready=%0b gh=%03h", ready, pred_ghist), "ready=0 gh=000");

        // sweep length, with stimulus during the sweep (R10)
        n = 0;
        while (ready !== 1'b1 && n < 5000) begin
            @(posedge clk);
            n++;
            #1;
            if (n == 10) begin
                pred_valid = 1'b1; pred_pc = 32'h40;
                upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = 1'b1;
                upd_mispredict = 1'b1; upd_ghist = 12'hfff;
            end
            if (n == 100) begin
                pred_valid = 1'b0; upd_valid = 1'b0; upd_mispredict = 1'b0;
            end
        end
        check("R1", n == 4096, $sformatf("%0d", n), "4096");

        cur_tag = "R10 ignored while clearing";
        do_pred(32'h40, snap, pt);
        cur_tag = "R1 reset state";
        do_pred(32'h80, snap, pt);

        // R10: an update without mispredict leaves history alone
        do_upd(32'h80, 1'b1, m_ghr, 1'b0);
        cur_tag = "R10 no-mispredict update";
        do_pred(32'h84, snap, pt);

        // R8 / R2: always-taken branch fills its history, counter saturates
        for (int i = 0; i < 20; i++) do_upd(32'h200, 1'b1, m_ghr, 1'b0);
        cur_tag = "R2 R8 local history";
        do_pred(32'h200, snap, pt);

        // R3 / R7: train one global index
        do_upd(32'h600, 1'b0, 12'h055, 1'b1);
        for (int i = 0; i < 4; i++) do_upd(32'h600, 1'b1, 12'h0ab, 1'b0);
        cur_tag = "R3 R7 global counter";
        do_pred(32'h604, snap, pt);

        // R9 / R4: disagreement moves chooser to global
        do_upd(32'h200, 1'b0, 12'h123, 1'b0);
        do_upd(32'h200, 1'b0, 12'h123, 1'b0);
        do_upd(32'h700, 1'b1, 12'h091, 1'b1);
        cur_tag = "R4 R9 chooser";
        do_pred(32'h700, snap, pt);

        // R5: back-to-back speculative shifts
        cur_tag = "R5 speculative shift";
        for (int i = 0; i < 3; i++) do_pred(32'h200 + 32'(i * 4), snap, pt);

        // R6: repair wins over same-cycle prediction
        cur_tag = "R6 same-cycle";
        do_both(32'h300, 32'h304, 1'b1, 12'h5a5);
        cur_tag = "R6 repaired history";
        do_pred(32'h300, snap, pt);

        // mixed run of looping branches
        cur_tag = "R2 R3 R4 R7 R8 R9 mixed";
        lfsr = 32'h1d872b41;
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        for (int i = 0; i < 1500; i++) begin
            int  k;
            bit  t;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            k = int'(lfsr[2:0]);
            t = (cnt[k] % (k + 2)) != 0;
            cnt[k]++;
            do_pred(32'h1000 + 32'(k * 4), snap, pt);
            do_upd(32'h1000 + 32'(k * 4), t, snap, t != pt);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule